// File: doc/BRIEF.md
# Debounced Event Accumulator with Channel Hop Scheduler

This block turns a raw contact input into counted events and decides when a packet should go out and on which radio channel. The contact idles high; a closure pulls it low. The low level has to hold for a programmable number of millisecond ticks before it counts as one event, and a release has to hold for the same time before a new closure is accepted. Each event adds one to a 16-bit running total. That total can be loaded with any starting value.

A programmable interval sets how many events pass between sends. When the total reaches the capture value, the block asks a downstream packet framer to send. The capture value is the total at the previous arming plus the interval, taken modulo 65536. The request carries the total and is held until the framer acknowledges it. Each completed send moves a pointer through a fixed 25-entry channel sequence. That sequence is a permutation, so every channel is used once before any channel repeats. Events that arrive during a send are still counted. One capture hit during a send is held and presented as soon as the current send completes.

The debouncer has four states. DB_IDLE goes to DB_WAIT when the input falls. DB_WAIT goes back to DB_IDLE if the input returns high, or to DB_HELD once enough ticks have passed, and that transition emits the event. DB_HELD goes to DB_REL when the input rises. DB_REL goes back to DB_HELD if the input falls again, or to DB_IDLE once enough ticks have passed. The scheduler has three states. SC_ARM computes the capture value and goes to SC_RUN. SC_RUN goes to SC_SEND on a capture hit. SC_SEND goes to SC_RUN on acknowledge when nothing is queued, and stays in SC_SEND when a queued or same-cycle hit exists. A configuration load forces SC_ARM from any state.

Top module: `evt_hop_sched`

## Requirements
- R1: With the input idling high, a closure held low for at least the debounce time adds exactly one to `evt_total`, and a second event needs a debounced release first.
- R2: A low pulse shorter than the debounce time adds nothing. A return high during the wait restarts the tick count, so two short low pulses split by a brief high add nothing.
- R3: The debounce time is `cfg_debounce` millisecond ticks (1 to 255); the value 0 selects 50 ticks.
- R4: `evt_total` is a 16-bit up counter that wraps from 65535 to 0 and changes by at most one per cycle; a `cfg_load` pulse sets it to `cfg_preload` in the next cycle.
- R5: `cfg_interval` (1 to 10000) sets the number of events between sends; the value 0 behaves as 1.
- R6: A send is requested exactly when the total reaches preload plus a whole multiple of the interval (mod 65536), and `send_total` then equals that total.
- R7: `send_req` stays high and `send_total` stays unchanged until `send_done` is seen high in a cycle with `send_req` high.
- R8: Events during a send are counted. A capture hit during a send is presented, with its own total, in the cycle after the acknowledge of the current send.
- R9: `chan_idx` changes only on an acknowledged send. The k-th send (counting from 0) uses channel (7k+3) mod 25, so all 25 values 0 to 24 appear once per cycle of 25 sends.
- R10: After reset `evt_total` is 0, `send_req` is low and `chan_idx` is 3.
- R11: `cfg_load` cancels any send in progress without moving the channel and re-arms the interval from the preload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_in | input | 1 | Raw contact input, idles high, low while closed |
| ms_tick | input | 1 | One-cycle strobe per millisecond |
| cfg_interval | input | 14 | Events between sends (0 treated as 1) |
| cfg_debounce | input | 8 | Debounce time in ticks (0 selects 50) |
| cfg_preload | input | 16 | Starting value for the running total |
| cfg_load | input | 1 | Pulse: load preload, re-arm, cancel send |
| send_done | input | 1 | Framer acknowledge of the current send |
| send_req | output | 1 | Send request to the framer |
| send_total | output | 16 | Running total carried by the request |
| evt_total | output | 16 | Current running total |
| chan_idx | output | 5 | Channel number for the current or next send |

## Verification
The two actions that can fall in one cycle are the framer acknowledge and a new capture hit from a fresh event. The acknowledge must close the current send, and the hit must open the next send with its own total, without loss or duplication. This is provoked by a responder whose acknowledge delay is drawn at random over a window that sweeps across the moment a new event lands, over many short intervals. A directed case also holds the acknowledge back while two capture hits occur. The outcome is judged by checking every presented total and channel against a model queue built from the event count and the interval. The queue must drain exactly and `evt_total` must match the model after each round.

// File: rtl/evt_hop_pkg.sv
package evt_hop_pkg;

    typedef enum logic [1:0] {
        DB_IDLE,
        DB_WAIT,
        DB_HELD,
        DB_REL
    } db_state_t;

    typedef enum logic [1:0] {
        SC_ARM,
        SC_RUN,
        SC_SEND
    } sc_state_t;

endpackage

// File: rtl/evt_debounce.sv
module evt_debounce
    import evt_hop_pkg::*;
#(
    parameter int DB_W   = 8,
    parameter int DEF_DB = 50
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sw_raw,
    input  logic            ms_tick,
    input  logic [DB_W-1:0] cfg_db,
    output logic            evt_o
);

    logic [1:0]      sync_q;
    logic            sw_s;
    db_state_t       st_q, st_d;
    logic [DB_W-1:0] cnt_q;
    logic [DB_W-1:0] lim;
    logic            hit;

    assign sw_s = sync_q[1];
    assign lim  = (cfg_db == '0) ? DB_W'(DEF_DB) : cfg_db;
    assign hit  = (cnt_q == lim - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], sw_raw};
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= DB_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            DB_IDLE: if (!sw_s) st_d = DB_WAIT;
            DB_WAIT: begin
                if (sw_s)                st_d = DB_IDLE;
                else if (ms_tick && hit) st_d = DB_HELD;
            end
            DB_HELD: if (sw_s) st_d = DB_REL;
            DB_REL: begin
                if (!sw_s)               st_d = DB_HELD;
                else if (ms_tick && hit) st_d = DB_IDLE;
            end
            default: st_d = DB_IDLE;
        endcase
    end

    // outputs and tick counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            evt_o <= 1'b0;
        end else begin
            if (st_d != st_q) cnt_q <= '0;
            else if (ms_tick) cnt_q <= cnt_q + 1'b1;
            evt_o <= (st_q == DB_WAIT) && (st_d == DB_HELD);
        end
    end

    // R1: one closure gives a single-cycle event
    assert_evt_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |=> !evt_o)
        else $error("event pulse longer than one cycle");

    // R2: an event only follows a cycle with the synchronised input low
    assert_evt_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> $past(!sw_s))
        else $error("event without low input");

endmodule

// File: rtl/evt_sched.sv
module evt_sched
    import evt_hop_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int IV_W  = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic [IV_W-1:0]  cfg_interval,
    input  logic [CNT_W-1:0] cfg_preload,
    input  logic             cfg_load,
    input  logic             send_done,
    output logic             send_req,
    output logic [CNT_W-1:0] send_total,
    output logic [CNT_W-1:0] total,
    output logic             adv
);

    sc_state_t        st_q, st_d;
    logic [CNT_W-1:0] total_q, cap_q, sendv_q, pend_v_q;
    logic             pend_q;
    logic [CNT_W-1:0] iv_eff, inc_total;
    logic             match, done_now;

    assign iv_eff    = (cfg_interval == '0) ? CNT_W'(1) : CNT_W'(cfg_interval);
    assign inc_total = total_q + 1'b1;
    assign match     = evt && (inc_total == cap_q) && (st_q != SC_ARM);
    assign done_now  = (st_q == SC_SEND) && send_done;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SC_ARM;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SC_ARM:  st_d = SC_RUN;
            SC_RUN:  if (match) st_d = SC_SEND;
            SC_SEND: if (send_done && !match && !pend_q) st_d = SC_RUN;
            default: st_d = SC_ARM;
        endcase
        if (cfg_load) st_d = SC_ARM;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            total_q  <= '0;
            cap_q    <= '0;
            sendv_q  <= '0;
            pend_v_q <= '0;
            pend_q   <= 1'b0;
        end else if (cfg_load) begin
            total_q <= cfg_preload;
            pend_q  <= 1'b0;
        end else begin
            if (evt) total_q <= inc_total;
            unique case (st_q)
                SC_ARM: cap_q <= (evt ? inc_total : total_q) + iv_eff;
                SC_RUN: begin
                    if (match) begin
                        sendv_q <= inc_total;
                        cap_q   <= inc_total + iv_eff;
                    end
                end
                SC_SEND: begin
                    if (send_done) begin
                        if (match) begin
                            sendv_q <= inc_total;
                            cap_q   <= inc_total + iv_eff;
                        end else if (pend_q) begin
                            sendv_q <= pend_v_q;
                            pend_q  <= 1'b0;
                        end
                    end else if (match) begin
                        pend_q   <= 1'b1;
                        pend_v_q <= inc_total;
                        cap_q    <= inc_total + iv_eff;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    assign send_req   = (st_q == SC_SEND);
    assign send_total = sendv_q;
    assign total      = total_q;
    assign adv        = done_now && !cfg_load;

    assert_total_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> (total_q == $past(total_q)) || (total_q == CNT_W'($past(total_q) + 1'b1)))
        else $error("total jumped");

    assert_load_value_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> !send_req && (total_q == $past(cfg_preload)))
        else $error("load did not cancel and preload");

    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (send_req && !send_done && !cfg_load) |=> send_req && $stable(send_total))
        else $error("request dropped or changed before acknowledge");

    assert_send_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(send_req) |-> (send_total == total_q))
        else $error("request carries wrong total");

    assert_no_pend_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> !match)
        else $error("second queued send lost");

endmodule

// File: rtl/evt_hop.sv
module evt_hop #(
    parameter int NUM_CH = 25,
    parameter int STRIDE = 7,
    parameter int OFFSET = 3,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    output logic [CH_W-1:0] chan
);

    logic [CH_W-1:0] tbl [NUM_CH];
    logic [CH_W-1:0] ptr_q;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_tbl
        assign tbl[g] = CH_W'((g * STRIDE + OFFSET) % NUM_CH);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             ptr_q <= '0;
        else if (adv && ptr_q == CH_W'(NUM_CH - 1)) ptr_q <= '0;
        else if (adv)                           ptr_q <= ptr_q + 1'b1;
    end

    assign chan = tbl[ptr_q];

    assert_chan_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        chan < CH_W'(NUM_CH))
        else $error("channel out of range");

    assert_chan_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(ptr_q))
        else $error("channel moved without a send");

    assert_chan_move_R9: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (ptr_q != $past(ptr_q)))
        else $error("channel did not move on a send");

endmodule

// File: rtl/evt_hop_sched.sv
module evt_hop_sched #(
    parameter int CNT_W  = 16,
    parameter int IV_W   = 14,
    parameter int DB_W   = 8,
    parameter int DEF_DB = 50,
    parameter int NUM_CH = 25,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_in,
    input  logic             ms_tick,
    input  logic [IV_W-1:0]  cfg_interval,
    input  logic [DB_W-1:0]  cfg_debounce,
    input  logic [CNT_W-1:0] cfg_preload,
    input  logic             cfg_load,
    input  logic             send_done,
    output logic             send_req,
    output logic [CNT_W-1:0] send_total,
    output logic [CNT_W-1:0] evt_total,
    output logic [CH_W-1:0]  chan_idx
);

    logic evt;
    logic adv;

    evt_debounce #(.DB_W(DB_W), .DEF_DB(DEF_DB)) u_db (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_raw  (sw_in),
        .ms_tick (ms_tick),
        .cfg_db  (cfg_debounce),
        .evt_o   (evt)
    );

    evt_sched #(.CNT_W(CNT_W), .IV_W(IV_W)) u_sc (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt          (evt),
        .cfg_interval (cfg_interval),
        .cfg_preload  (cfg_preload),
        .cfg_load     (cfg_load),
        .send_done    (send_done),
        .send_req     (send_req),
        .send_total   (send_total),
        .total        (evt_total),
        .adv          (adv)
    );

    evt_hop #(.NUM_CH(NUM_CH)) u_hop (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .chan  (chan_idx)
    );

endmodule

// File: tb/evt_hop_sched_tb.sv
`timescale 1ns/1ps
module evt_hop_sched_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_in = 1'b1;
    logic        ms_tick = 1'b0;
    logic [13:0] cfg_interval = 14'd3;
    logic [7:0]  cfg_debounce = 8'd2;
    logic [15:0] cfg_preload = 16'd0;
    logic        cfg_load = 1'b0;
    logic        send_done = 1'b0;
    logic        send_req;
    logic [15:0] send_total, evt_total;
    logic [4:0]  chan_idx;

    int n_chk = 0;
    int n_fail = 0;
    int sends_done = 0;
    bit resp_en = 1'b0;
    bit finished = 1'b0;
    logic [15:0] exp_total = 16'd0;
    logic [15:0] exp_cap = 16'd3;
    logic [15:0] eff_iv = 16'd3;
    logic [15:0] expq[$];

    always #2 clk = ~clk;

    evt_hop_sched dut_i (
        .clk(clk), .rst_n(rst_n), .sw_in(sw_in), .ms_tick(ms_tick),
        .cfg_interval(cfg_interval), .cfg_debounce(cfg_debounce),
        .cfg_preload(cfg_preload), .cfg_load(cfg_load), .send_done(send_done),
        .send_req(send_req), .send_total(send_total), .evt_total(evt_total),
        .chan_idx(chan_idx)
    );

    function automatic logic [4:0] chan_of(input int k);
        return 5'(((k % 25) * 7 + 3) % 25);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // bench model of one debounced event
    task automatic model_event();
        exp_total = exp_total + 16'd1;
        if (exp_total == exp_cap) begin
            expq.push_back(exp_total);
            exp_cap = exp_total + eff_iv;
        end
    endtask

    task automatic press(input int lim);
        model_event();
        sw_in = 1'b0;
        repeat ((lim + 2) * 4) @(negedge clk);
        sw_in = 1'b1;
        repeat ((lim + 2) * 4) @(negedge clk);
    endtask

    task automatic do_load(input logic [15:0] pre, input logic [13:0] iv);
        cfg_interval = iv;
        cfg_preload  = pre;
        eff_iv = (iv == 14'd0) ? 16'd1 : 16'(iv);
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        exp_total = pre;
        exp_cap = pre + eff_iv;
        expq.delete();
        @(negedge clk);
    endtask

    task automatic drain();
        repeat (40) @(negedge clk);
    endtask

    // millisecond strobe, one cycle in four
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            ms_tick = 1'b1;
            @(negedge clk);
            ms_tick = 1'b0;
        end
    end

    // framer responder: random acknowledge delay
    initial begin
        forever begin
            @(negedge clk);
            if (resp_en && send_req === 1'b1) begin
                automatic logic [15:0] v = send_total;
                automatic int d = $urandom_range(0, 6);
                repeat (d) begin
                    @(negedge clk);
                    chk("R7 hold", {15'd0, send_req, send_total}, {16'd1, v});
                end
                if (expq.size() == 0) begin
                    chk("R6 unexpected send", 32'(send_total), 32'hFFFF_FFFF);
                end else begin
                    chk("R6 send value", 32'(send_total), 32'(expq.pop_front()));
                end
                chk("R9 channel", 32'(chan_idx), 32'(chan_of(sends_done)));
                send_done = 1'b1;
                @(negedge clk);
                send_done = 1'b0;
                sends_done++;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 total", 32'(evt_total), 0);
        chk("R10 send_req", 32'(send_req), 0);
        chk("R10 chan", 32'(chan_idx), 3);
        @(negedge clk);

        // R1 basic closures, interval 3
        resp_en = 1'b1;
        for (int i = 0; i < 3; i++) press(2);
        drain();
        chk("R1 total", 32'(evt_total), 3);
        chk("R6 queue drained", expq.size(), 0);
        chk("R9 one send", sends_done, 1);

        // R2 short pulse and restart
        cfg_debounce = 8'd3;
        sw_in = 1'b0; repeat (7) @(negedge clk);
        sw_in = 1'b1; repeat (3) @(negedge clk);
        sw_in = 1'b0; repeat (7) @(negedge clk);
        sw_in = 1'b1; repeat (30) @(negedge clk);
        chk("R2 bounce ignored", 32'(evt_total), 3);

        // R3 default debounce of 50 ticks
        cfg_debounce = 8'd0;
        sw_in = 1'b0; repeat (47 * 4 - 1) @(negedge clk);
        sw_in = 1'b1; repeat (40) @(negedge clk);
        chk("R3 short of 50", 32'(evt_total), 3);
        press(50);
        drain();
        chk("R3 50 ticks counted", 32'(evt_total), 4);

        // R4 preload and wrap
        cfg_debounce = 8'd1;
        do_load(16'd65533, 14'd2);
        chk("R4 preload", 32'(evt_total), 65533);
        for (int i = 0; i < 3; i++) press(1);
        drain();
        chk("R4 wrap", 32'(evt_total), 0);
        chk("R6 wrap sends", expq.size(), 0);

        // R5 interval 0 acts as 1; R9 more than 25 sends
        do_load(16'd500, 14'd0);
        for (int i = 0; i < 26; i++) press(1);
        drain();
        chk("R5 total", 32'(evt_total), 526);
        chk("R5 every event sent", expq.size(), 0);
        chk("R9 channel after wrap", 32'(chan_idx), 32'(chan_of(sends_done)));

        // random rounds, acknowledge sweeping across event arrival
        for (int r = 0; r < 6; r++) begin
            automatic logic [13:0] iv = 14'($urandom_range(0, 4));
            automatic logic [15:0] pre = 16'($urandom);
            if (r == 2) pre = 16'd65530;
            cfg_debounce = 8'($urandom_range(1, 3));
            do_load(pre, iv);
            for (int i = 0; i < 15; i++) press(int'(cfg_debounce));
            drain();
            chk("R1 random total", 32'(evt_total), 32'(exp_total));
            chk("R6 random drained", expq.size(), 0);
        end

        // R8 hit during a held send
        resp_en = 1'b0;
        cfg_debounce = 8'd1;
        do_load(16'd1000, 14'd2);
        for (int i = 0; i < 4; i++) press(1);
        chk("R8 request held", 32'(send_req), 1);
        chk("R7 first value kept", 32'(send_total), 1002);
        chk("R8 events counted", 32'(evt_total), 1004);
        repeat (20) @(negedge clk);
        chk("R7 still held", {15'd0, send_req, send_total}, {16'd1, 16'd1002});
        resp_en = 1'b1;
        drain();
        chk("R8 both sent", expq.size(), 0);
        chk("R8 idle after", 32'(send_req), 0);

        // R11 load cancels a send
        resp_en = 1'b0;
        for (int i = 0; i < 2; i++) press(1);
        chk("R11 request pending", 32'(send_req), 1);
        begin
            automatic logic [4:0] ch = chan_idx;
            do_load(16'd100, 14'd2);
            chk("R11 cancelled", 32'(send_req), 0);
            chk("R11 preload", 32'(evt_total), 100);
            chk("R11 channel kept", 32'(chan_idx), 32'(ch));
        end
        resp_en = 1'b1;
        for (int i = 0; i < 2; i++) press(1);
        drain();
        chk("R11 re-armed", expq.size(), 0);
        chk("R11 total", 32'(evt_total), 102);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule